// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

The block is a watchdog built around a free-running 32-bit up-counter that advances once per clock while it is enabled. Each step is compared with a programmable match value. A match can raise a status flag and interrupt, send the counter back to zero, halt counting, start a reset pulse of programmable length on an internal and an external reset output, and change the level of an external match pin. Software refreshes the watchdog by requesting a counter clear and then re-enabling counting. The timeout is the match value divided by the counter clock rate.

Access is through a single-cycle 32-bit register bus. Writes take effect on the clock edge. Reads are combinational. `busIdx` is a word index, and the byte offset of each register is four times that index. A debug-halt input can freeze the count. A reset-cause flag records that a watchdog pulse was issued. Only the power-on reset clears that flag, so software can read it after the system reset that the pulse causes.

Top module: `match_watchdog`

## Requirements
- R1: After reset all eight registers read zero, and `matchIrq`, `intRstOut`, `extRstOut` and `matchPin` are low.
- R2: With control bit 0 set, the counter (index 2) increases by exactly one per clock. With control bit 0 clear it holds its value.
- R3: When control bit 2 is set and `debugHalt` is high, the counter holds. When either of them is low, counting proceeds normally.
- R4: Writing control bit 1 stops the counter and clears it to zero on the next edge. The bit clears itself one cycle after the counter reads zero. If bit 0 was written together with it, counting then resumes from zero.
- R5: When the counter steps onto the match value (index 4), status bit 0 (index 0) is set, and `matchIrq` goes high if match-config bit 0 (index 3) is set. Writing 1 to status bit 0 clears it. A counter that runs past the match does not set the bit again.
- R6: On a match, match-config bit 1 loads the counter with zero instead of the match value. Match-config bit 2 clears control bit 0, so the counter stops at the match value.
- R7: On a match, match-config bits 3 and 4 arm `intRstOut` and `extRstOut`. An armed output goes high on the cycle after the match and stays high for the pulse length (index 6, 16 bits) plus 2 cycles. An output that is not armed stays low.
- R8: Match-config bits 5 and 6 hold `intRstOut` and `extRstOut` high at once, with no match needed, and leave the reset-cause flag unchanged.
- R9: Pin-control bits [5:4] (index 5) choose the pin action on a match: 0 hold, 1 low, 2 high, 3 toggle. Bit 0 reads the current `matchPin` level, and a write to it sets that level.
- R10: Reset-cause bit 0 (index 7) is set when a match arms either reset output. It survives `rstN` and is cleared only by `porN`.
- R11: Writes to the counter (index 2) and to the reset-cause register (index 7) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rstN | input | 1 | Active-low system reset, asynchronous |
| porN | input | 1 | Active-low power-on reset, clears the reset-cause flag |
| busWe | input | 1 | Register write strobe |
| busIdx | input | 3 | Register word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busIdx` |
| debugHalt | input | 1 | Debugger halt indication |
| matchIrq | output | 1 | Match interrupt request |
| intRstOut | output | 1 | Internal reset pulse |
| extRstOut | output | 1 | External reset pulse |
| matchPin | output | 1 | External match pin |

## Verification
The counter is driven in four ways: free running, frozen by the debug input, cleared by the self-clearing request, and stopped or wrapped by a match. Comparing counter readings taken a known number of cycles apart shows the difference between a one-per-clock step, a hold, and a restart from zero. The match is approached with the interrupt, wrap, stop, pulse and pin actions each enabled alone. This ties every observed effect to a single configuration bit. The interrupt edge and the pulse width are checked to the exact cycle. The two resets are applied separately to show which state each one clears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_IRQ   = 3'd0,
    IDX_CTRL  = 3'd1,
    IDX_COUNT = 3'd2,
    IDX_MCFG  = 3'd3,
    IDX_MATCH = 3'd4,
    IDX_PIN   = 3'd5,
    IDX_PLEN  = 3'd6,
    IDX_CAUSE = 3'd7
  } regIdx_e;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } pinAct_e;

  // strobes from control to datapath
  typedef struct packed {
    logic incr;
    logic clr;
    logic wrapOnMatch;
    logic armInt;
    logic armExt;
  } dpCmd_t;

  // feedback from datapath to control
  typedef struct packed {
    logic hit;
    logic cntZero;
    logic pulseInt;
    logic pulseExt;
  } dpStat_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PLEN_W      = 16,
  parameter int PULSE_EXTRA = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] matchVal,
  input  logic [PLEN_W-1:0] pulseLen,
  output logic [DATA_W-1:0] counter,
  output dpStat_t           stat
);
  localparam int PCNT_W = PLEN_W + 1;

  logic [DATA_W-1:0] nextCount;
  logic [PCNT_W-1:0] pulseCnt;
  logic              pulseIntSel;
  logic              pulseExtSel;
  logic              hit;
  logic              trig;

  assign nextCount = counter + DATA_W'(1);
  // a match is seen only on the step onto the value, so it fires once per crossing
  assign hit  = cmd.incr && (nextCount == matchVal);
  assign trig = hit && (cmd.armInt || cmd.armExt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      counter <= '0;
    end else if (cmd.clr) begin
      counter <= '0;
    end else if (cmd.incr) begin
      counter <= (hit && cmd.wrapOnMatch) ? '0 : nextCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt    <= '0;
      pulseIntSel <= 1'b0;
      pulseExtSel <= 1'b0;
    end else if (trig) begin
      pulseCnt    <= PCNT_W'(pulseLen) + PCNT_W'(PULSE_EXTRA);
      pulseIntSel <= cmd.armInt;
      pulseExtSel <= cmd.armExt;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - PCNT_W'(1);
    end
  end

  always_comb begin
    stat.hit      = hit;
    stat.cntZero  = (counter == '0);
    stat.pulseInt = (pulseCnt != '0) && pulseIntSel;
    stat.pulseExt = (pulseCnt != '0) && pulseExtSel;
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PLEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              busWe,
  input  logic [IDX_W-1:0]  busIdx,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              debugHalt,
  input  logic [DATA_W-1:0] counter,
  input  dpStat_t           stat,
  output dpCmd_t            cmd,
  output logic [DATA_W-1:0] matchVal,
  output logic [PLEN_W-1:0] pulseLen,
  output logic [6:0]        matchCfg,
  output logic              irqFlag,
  output logic              pinQ,
  output logic              causeFlag
);
  logic    cntEn;
  logic    rstReq;
  logic    dbgEn;
  pinAct_e pinAct;

  logic wrIrq, wrCtrl, wrMcfg, wrMatch, wrPin, wrPlen;
  assign wrIrq   = busWe && (busIdx == IDX_IRQ);
  assign wrCtrl  = busWe && (busIdx == IDX_CTRL);
  assign wrMcfg  = busWe && (busIdx == IDX_MCFG);
  assign wrMatch = busWe && (busIdx == IDX_MATCH);
  assign wrPin   = busWe && (busIdx == IDX_PIN);
  assign wrPlen  = busWe && (busIdx == IDX_PLEN);

  always_comb begin
    cmd.incr        = cntEn && !rstReq && !(dbgEn && debugHalt);
    cmd.clr         = rstReq;
    cmd.wrapOnMatch = matchCfg[1];
    cmd.armInt      = matchCfg[3];
    cmd.armExt      = matchCfg[4];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEn  <= 1'b0;
      rstReq <= 1'b0;
      dbgEn  <= 1'b0;
    end else if (wrCtrl) begin
      {dbgEn, rstReq, cntEn} <= busWdata[2:0];
    end else begin
      if (rstReq && stat.cntZero) rstReq <= 1'b0;
      if (stat.hit && matchCfg[2]) cntEn <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchCfg <= '0;
      matchVal <= '0;
      pulseLen <= '0;
    end else begin
      if (wrMcfg)  matchCfg <= busWdata[6:0];
      if (wrMatch) matchVal <= busWdata;
      if (wrPlen)  pulseLen <= busWdata[PLEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (stat.hit) begin
      irqFlag <= 1'b1;
    end else if (wrIrq && busWdata[0]) begin
      irqFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinAct <= PIN_HOLD;
      pinQ   <= 1'b0;
    end else if (wrPin) begin
      pinAct <= pinAct_e'(busWdata[5:4]);
      pinQ   <= busWdata[0];
    end else if (stat.hit) begin
      case (pinAct)
        PIN_LOW:    pinQ <= 1'b0;
        PIN_HIGH:   pinQ <= 1'b1;
        PIN_TOGGLE: pinQ <= !pinQ;
        default:    pinQ <= pinQ;
      endcase
    end
  end

  // kept in the power-on domain so a watchdog-caused system reset leaves it set
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      causeFlag <= 1'b0;
    end else if (stat.hit && (matchCfg[3] || matchCfg[4])) begin
      causeFlag <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busIdx)
      IDX_IRQ:   busRdata[0]        = irqFlag;
      IDX_CTRL:  busRdata[2:0]      = {dbgEn, rstReq, cntEn};
      IDX_COUNT: busRdata           = counter;
      IDX_MCFG:  busRdata[6:0]      = matchCfg;
      IDX_MATCH: busRdata           = matchVal;
      IDX_PIN:   begin
                   busRdata[5:4] = pinAct;
                   busRdata[0]   = pinQ;
                 end
      IDX_PLEN:  busRdata[PLEN_W-1:0] = pulseLen;
      default:   busRdata[0]        = causeFlag;
    endcase
  end
endmodule

// File: rtl/match_watchdog.sv
module match_watchdog
  import wdog_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PLEN_W      = 16,
  parameter int PULSE_EXTRA = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              busWe,
  input  logic [2:0]        busIdx,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              debugHalt,
  output logic              matchIrq,
  output logic              intRstOut,
  output logic              extRstOut,
  output logic              matchPin
);
  dpCmd_t            cmd;
  dpStat_t           stat;
  logic [DATA_W-1:0] counter;
  logic [DATA_W-1:0] matchVal;
  logic [PLEN_W-1:0] pulseLen;
  logic [6:0]        matchCfg;
  logic              irqFlag;
  logic              causeFlag;

  wdog_ctrl #(.DATA_W(DATA_W), .PLEN_W(PLEN_W)) ctrlU (
    .clk(clk), .rstN(rstN), .porN(porN),
    .busWe(busWe), .busIdx(busIdx), .busWdata(busWdata), .busRdata(busRdata),
    .debugHalt(debugHalt), .counter(counter), .stat(stat), .cmd(cmd),
    .matchVal(matchVal), .pulseLen(pulseLen), .matchCfg(matchCfg),
    .irqFlag(irqFlag), .pinQ(matchPin), .causeFlag(causeFlag)
  );

  wdog_dp #(.DATA_W(DATA_W), .PLEN_W(PLEN_W), .PULSE_EXTRA(PULSE_EXTRA)) dpU (
    .clk(clk), .rstN(rstN), .cmd(cmd), .matchVal(matchVal),
    .pulseLen(pulseLen), .counter(counter), .stat(stat)
  );

  assign matchIrq  = irqFlag && matchCfg[0];
  assign intRstOut = stat.pulseInt || matchCfg[5];
  assign extRstOut = stat.pulseExt || matchCfg[6];
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              porN,
  input logic              busWe,
  input logic              hit,
  input logic              clr,
  input logic [DATA_W-1:0] counter,
  input logic [6:0]        matchCfg,
  input logic              matchIrq,
  input logic              intRstOut,
  input logic              causeFlag
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (counter != $past(counter)) |-> ((counter == $past(counter) + DATA_W'(1)) || (counter == '0))); // R2

  AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (counter == '0)); // R4

  AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (hit && matchCfg[0] && !busWe) |=> matchIrq); // R5

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (hit && matchCfg[2] && !busWe) |=> ##1 $stable(counter)); // R6

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rstN)
    (hit && matchCfg[3] && !busWe) |=> intRstOut); // R7

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!porN)
    !$fell(causeFlag)); // R10
endmodule

bind match_watchdog wdog_checker #(.DATA_W(DATA_W)) chkU (
  .clk(clk), .rstN(rstN), .porN(porN), .busWe(busWe),
  .hit(stat.hit), .clr(cmd.clr), .counter(counter), .matchCfg(matchCfg),
  .matchIrq(matchIrq), .intRstOut(intRstOut), .causeFlag(causeFlag)
);

// File: tb/match_watchdog_test.sv
`timescale 1ns/1ps
module match_watchdog_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        porN = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busIdx = 3'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        debugHalt = 1'b0;
  logic        matchIrq, intRstOut, extRstOut, matchPin;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] I_IRQ = 3'd0, I_CTRL = 3'd1, I_CNT = 3'd2, I_MCFG = 3'd3,
                         I_MATCH = 3'd4, I_PIN = 3'd5, I_PLEN = 3'd6, I_CAUSE = 3'd7;

  always #4 clk = ~clk;

  match_watchdog uut (
    .clk(clk), .rstN(rstN), .porN(porN), .busWe(busWe), .busIdx(busIdx),
    .busWdata(busWdata), .busRdata(busRdata), .debugHalt(debugHalt),
    .matchIrq(matchIrq), .intRstOut(intRstOut), .extRstOut(extRstOut), .matchPin(matchPin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busIdx = idx; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    busIdx = idx;
    #1 d = busRdata;
  endtask

  task automatic zeroCounter();
    wr(I_CTRL, 32'h2);
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk($sformatf("R1 reg%0d", i), v, 32'h0);
    end
    chk("R1 outputs", {28'd0, matchIrq, intRstOut, extRstOut, matchPin}, 32'h0);
  endtask

  task automatic testCount();
    logic [31:0] a, b;
    zeroCounter();
    wr(I_MATCH, 32'hFFFF_0000);
    wr(I_CTRL, 32'h1);
    rd(I_CNT, a);
    repeat (4) @(negedge clk);
    rd(I_CNT, b);
    chk("R2 step per clock", b, a + 32'd5);
    wr(I_CTRL, 32'h0);
    rd(I_CNT, a);
    repeat (6) @(negedge clk);
    rd(I_CNT, b);
    chk("R2 hold when disabled", b, a);
  endtask

  task automatic testDebug();
    logic [31:0] a, b;
    zeroCounter();
    debugHalt = 1'b1;
    wr(I_CTRL, 32'h5);
    rd(I_CNT, a);
    repeat (5) @(negedge clk);
    rd(I_CNT, b);
    chk("R3 frozen", b, a);
    debugHalt = 1'b0;
    rd(I_CNT, a);
    repeat (4) @(negedge clk);
    rd(I_CNT, b);
    chk("R3 resumes", b, a + 32'd5);
    wr(I_CTRL, 32'h1);
    debugHalt = 1'b1;
    rd(I_CNT, a);
    repeat (4) @(negedge clk);
    rd(I_CNT, b);
    chk("R3 halt ignored when not enabled", b, a + 32'd5);
    debugHalt = 1'b0;
  endtask

  task automatic testReq();
    logic [31:0] v;
    wr(I_CTRL, 32'h1);
    repeat (5) @(negedge clk);
    wr(I_CTRL, 32'h3);
    rd(I_CNT, v);
    chk("R4 cleared", v, 32'h0);
    rd(I_CTRL, v);
    chk("R4 request self-clears", v, 32'h1);
    rd(I_CNT, v);
    chk("R4 counts after clear", v, 32'h1);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    zeroCounter();
    wr(I_IRQ, 32'h1);
    wr(I_MATCH, 32'd20);
    wr(I_MCFG, 32'h1);
    wr(I_CTRL, 32'h1);
    repeat (19) @(negedge clk);
    chk("R5 irq before match", {31'd0, matchIrq}, 32'h0);
    @(negedge clk);
    chk("R5 irq on match", {31'd0, matchIrq}, 32'h1);
    rd(I_IRQ, v);
    chk("R5 status set", v, 32'h1);
    wr(I_IRQ, 32'h1);
    repeat (10) @(negedge clk);
    rd(I_IRQ, v);
    chk("R5 cleared and not set again", v, 32'h0);
    wr(I_CTRL, 32'h0);
  endtask

  task automatic testStop();
    logic [31:0] v;
    zeroCounter();
    wr(I_MATCH, 32'd10);
    wr(I_MCFG, 32'h4);
    wr(I_CTRL, 32'h1);
    repeat (30) @(negedge clk);
    rd(I_CNT, v);
    chk("R6 stop at match", v, 32'd10);
    rd(I_CTRL, v);
    chk("R6 enable cleared", v, 32'h0);
  endtask

  task automatic testWrap();
    logic [31:0] v;
    logic [31:0] mx;
    mx = 0;
    zeroCounter();
    wr(I_IRQ, 32'h1);
    wr(I_MATCH, 32'd8);
    wr(I_MCFG, 32'h2);
    wr(I_CTRL, 32'h1);
    for (int i = 0; i < 24; i++) begin
      rd(I_CNT, v);
      if (v > mx) mx = v;
    end
    chk("R6 wrap max value", mx, 32'd7);
    rd(I_IRQ, v);
    chk("R5 status on wrap match", v, 32'h1);
    wr(I_CTRL, 32'h0);
    wr(I_IRQ, 32'h1);
  endtask

  task automatic testForce();
    logic [31:0] v;
    wr(I_MCFG, 32'h20);
    chk("R8 force int", {30'd0, intRstOut, extRstOut}, 32'h2);
    wr(I_MCFG, 32'h40);
    chk("R8 force ext", {30'd0, intRstOut, extRstOut}, 32'h1);
    wr(I_MCFG, 32'h0);
    rd(I_CAUSE, v);
    chk("R8 cause untouched by force", v, 32'h0);
  endtask

  task automatic testPulse();
    int hi, he;
    logic [31:0] v;
    zeroCounter();
    wr(I_PLEN, 32'd5);
    wr(I_MATCH, 32'd6);
    wr(I_MCFG, 32'h18);
    wr(I_CTRL, 32'h1);
    hi = 0; he = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (intRstOut) hi++;
      if (extRstOut) he++;
    end
    chk("R7 int pulse width", 32'(hi), 32'd7);
    chk("R7 ext pulse width", 32'(he), 32'd7);
    rd(I_CAUSE, v);
    chk("R10 cause set", v, 32'h1);
    zeroCounter();
    wr(I_MCFG, 32'h08);
    wr(I_CTRL, 32'h1);
    hi = 0; he = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (intRstOut) hi++;
      if (extRstOut) he++;
    end
    chk("R7 int only width", 32'(hi), 32'd7);
    chk("R7 ext not armed", 32'(he), 32'd0);
    wr(I_MCFG, 32'h0);
  endtask

  task automatic testPin();
    logic [31:0] v;
    int tg;
    logic last;
    zeroCounter();
    wr(I_MCFG, 32'h0);
    wr(I_MATCH, 32'd5);
    wr(I_PIN, 32'h20);
    wr(I_CTRL, 32'h1);
    repeat (10) @(negedge clk);
    rd(I_PIN, v);
    chk("R9 drive high", v, 32'h21);
    chk("R9 pin high", {31'd0, matchPin}, 32'h1);
    zeroCounter();
    wr(I_PIN, 32'h11);
    chk("R9 pin written", {31'd0, matchPin}, 32'h1);
    wr(I_CTRL, 32'h1);
    repeat (10) @(negedge clk);
    rd(I_PIN, v);
    chk("R9 drive low", v, 32'h10);
    zeroCounter();
    wr(I_PIN, 32'h30);
    wr(I_MATCH, 32'd4);
    wr(I_MCFG, 32'h2);
    wr(I_CTRL, 32'h1);
    tg = 0;
    last = matchPin;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (matchPin != last) tg++;
      last = matchPin;
    end
    chk("R9 toggle count", 32'(tg >= 3), 32'h1);
    wr(I_CTRL, 32'h0);
    wr(I_MCFG, 32'h0);
  endtask

  task automatic testReadOnly();
    logic [31:0] a, b;
    rd(I_CNT, a);
    wr(I_CNT, 32'h1234_5678);
    rd(I_CNT, b);
    chk("R11 counter write ignored", b, a);
    wr(I_CAUSE, 32'h0);
    rd(I_CAUSE, b);
    chk("R11 cause write ignored", b, 32'h1);
  endtask

  task automatic testResets();
    logic [31:0] v;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rd(I_CAUSE, v);
    chk("R10 survives system reset", v, 32'h1);
    rd(I_MATCH, v);
    chk("R1 match cleared by reset", v, 32'h0);
    @(negedge clk);
    porN = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1;
    rd(I_CAUSE, v);
    chk("R10 cleared by power-on reset", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    porN = 1'b1;
    rstN = 1'b1;
    testReset();
    testCount();
    testDebug();
    testReq();
    testIrq();
    testStop();
    testWrap();
    testForce();
    testPulse();
    testPin();
    testReadOnly();
    testResets();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule